// File: doc/BRIEF.md
# Per-Channel ADC Calibration Corrector

This block sits on the sample stream of a two-channel, 14-bit converter and turns each raw two's-complement code into a calibrated voltage in signed fixed point. Each sample carries a channel tag. The block multiplies the code by a per-channel scale factor and adds a per-channel offset. It then clamps the result to the output range and returns it three cycles later with the same tag. The scale factor already includes the nominal 1.055 V full-scale span, the gain error of the channel and the division by 2^13. Scale, offset and output all use signed Q2.22 format (24 bits, 22 fraction bits).

The block holds one coefficient group for each of seven sampling-frequency slots. A byte-wide frequency code picks the group for each sample. Software loads the coefficients through a plain write port into a shadow copy. The working copy reloads from the shadow copy only on cycles that carry no sample, so a burst of samples always sees one consistent coefficient group.

Top module: `adc_cal_corrector`

## Requirements
- R1: After a synchronous active-low reset, out_valid and out_data are 0 and every stored scale and offset is 0, so a sample taken before any write gives 0.
- R2: A write with cfg_addr = slot*4 + k stores cfg_wdata. k=0 is the channel 0 scale, k=1 the channel 0 offset, k=2 the channel 1 scale and k=3 the channel 1 offset. Writes to addresses 28 to 31 change nothing.
- R3: For a valid sample N (14-bit two's complement), out_data = N*scale + offset. The scale and offset are Q2.22, so the result is Q2.22.
- R4: freq_code 0 selects slot 0, and 50, 80, 100, 110, 120 and 125 select slots 1 to 6 in that order. Every other code selects slot 0.
- R5: A sample accepted at a clock edge appears with out_valid high and the same out_ch after the third rising edge, counting the edge that accepts it. Cycles without in_valid produce no output.
- R6: A sample tagged in_ch=0 uses the channel 0 scale and offset (k=0,1). A sample tagged in_ch=1 uses the channel 1 pair (k=2,3).
- R7: Results above 0x7FFFFF give 0x7FFFFF, and results below -0x800000 give 0x800000.
- R8: Samples use the working copy. At each edge where in_valid is low, the working copy takes on the shadow contents held before that edge. A write therefore affects only samples accepted after the first such edge that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 5 | Coefficient word address (slot*4 + k) |
| cfg_wdata | input | 24 | Coefficient value, signed Q2.22 |
| freq_code | input | 8 | Sampling-frequency code that selects the slot |
| in_valid | input | 1 | Sample present |
| in_ch | input | 1 | Channel tag of the sample |
| in_sample | input | 14 | Raw two's-complement code |
| out_valid | output | 1 | Corrected value present |
| out_ch | output | 1 | Channel tag of the corrected value |
| out_data | output | 24 | Corrected value, signed Q2.22 volts |

## Verification
A coefficient write and a sample can arrive in the same cycle. The sample must use the old coefficients, and the write must become visible only after the next cycle without a sample. The bench provokes this by issuing writes to the active slot in the middle of unbroken sample bursts and again at random times in a long mixed stream. A scoreboard model keeps its own shadow and working copies and updates them by the rule in R8. Each result is compared with that model for value, tag and arrival cycle.

// File: rtl/adc_cal_pkg.sv
// Shared constants and types for the calibration corrector.
// Assumes exactly seven frequency slots whose byte codes are listed below.
package adc_cal_pkg;

    localparam int NUM_SLOTS   = 7;
    localparam int FREQ_CODE_W = 8;

    // Byte code that names each slot, slot index order.
    localparam logic [FREQ_CODE_W-1:0] SLOT_CODE [NUM_SLOTS] = '{
        8'd0, 8'd50, 8'd80, 8'd100, 8'd110, 8'd120, 8'd125
    };

    // Position of a word inside one channel's coefficient pair.
    typedef enum logic {
        COEF_SCALE  = 1'b0,
        COEF_OFFSET = 1'b1
    } coef_kind_e;

endpackage

// File: rtl/cal_slot_decode.sv
// Maps a sampling-frequency byte code onto a coefficient slot index.
// Assumes slot codes are distinct; a code matching none selects slot 0.
module cal_slot_decode
    import adc_cal_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic [FREQ_CODE_W-1:0] freq_code,
    output logic [SLOT_W-1:0]      slot
);

    logic [NUM_SLOTS-1:0] hit;

    // One comparator per slot code.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign hit[i] = (freq_code == SLOT_CODE[i]);
    end

    // Pick the matching slot, defaulting to slot 0.
    always_comb begin
        slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) slot = SLOT_W'(i);
        end
    end

endmodule

// File: rtl/cal_coef_bank.sv
// Coefficient storage: a shadow copy written by the config port and a
// working copy read by the datapath. The working copy reloads from the
// shadow copy on every cycle that carries no sample.
// Assumes rd_slot < NUM_SLOTS and rd_ch < NUM_CH.
module cal_coef_bank
    import adc_cal_pkg::*;
#(
    parameter int COEF_W = 24,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int SLOT_W = 3,
    parameter int CH_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic                     smp_valid,
    input  logic [SLOT_W-1:0]        rd_slot,
    input  logic [CH_W-1:0]          rd_ch,
    output logic signed [COEF_W-1:0] rd_scale,
    output logic signed [COEF_W-1:0] rd_offset
);

    localparam int WORDS_PER_SLOT = 2 * NUM_CH;
    localparam int NUM_WORDS      = NUM_SLOTS * WORDS_PER_SLOT;
    localparam int IDX_W          = $clog2(NUM_WORDS);

    logic signed [COEF_W-1:0] shadow_q [NUM_WORDS];
    logic signed [COEF_W-1:0] active_q [NUM_WORDS];
    logic [IDX_W-1:0]         base_idx;
    logic                     wr_hit;

    assign wr_hit = wr_en && (int'(wr_addr) < NUM_WORDS);

    // Config writes land in the shadow copy; out-of-range addresses dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) shadow_q[w] <= '0;
        end else if (wr_hit) begin
            shadow_q[IDX_W'(wr_addr)] <= wr_data;
        end
    end

    // Working copy follows the shadow copy only while no sample is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) active_q[w] <= '0;
        end else if (!smp_valid) begin
            for (int w = 0; w < NUM_WORDS; w++) active_q[w] <= shadow_q[w];
        end
    end

    // Read the scale/offset pair of the requested slot and channel.
    always_comb begin
        base_idx  = IDX_W'(int'(rd_slot) * WORDS_PER_SLOT + int'(rd_ch) * 2);
        rd_scale  = active_q[base_idx + IDX_W'(COEF_SCALE)];
        rd_offset = active_q[base_idx + IDX_W'(COEF_OFFSET)];
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_chk
        // R8: working copy is frozen across any cycle carrying a sample.
        a_r8_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            smp_valid |=> $stable(active_q[w]));
        // R2: an addressed write lands exactly in its word.
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_addr) == w) |=> (shadow_q[w] == $past(wr_data)));
        // R2: a word not addressed by a write keeps its value.
        a_r2_other_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && int'(wr_addr) == w) |=> $stable(shadow_q[w]));
    end

endmodule

// File: rtl/cal_mac_pipe.sv
// Three-stage multiply-add: stage 1 registers sample and coefficients,
// stage 2 forms the product, stage 3 adds the offset and clamps.
// Assumes coefficients and output share one fixed-point format.
module cal_mac_pipe #(
    parameter int SAMPLE_W = 14,
    parameter int COEF_W   = 24,
    parameter int CH_W     = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic signed [COEF_W-1:0]   in_scale,
    input  logic signed [COEF_W-1:0]   in_offset,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_ch,
    output logic signed [COEF_W-1:0]   out_data
);

    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int HI_W   = SUM_W - COEF_W + 1;

    logic                       s1_valid, s2_valid;
    logic [CH_W-1:0]            s1_ch, s2_ch;
    logic signed [SAMPLE_W-1:0] s1_sample;
    logic signed [COEF_W-1:0]   s1_scale, s1_offset, s2_offset;
    logic signed [PROD_W-1:0]   s2_prod;
    logic signed [SUM_W-1:0]    sum_w;
    logic [HI_W-1:0]            sum_hi;
    logic signed [COEF_W-1:0]   clamped;

    // Stage 1: capture the sample with the coefficients chosen for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_ch <= '0; s1_sample <= '0;
            s1_scale <= '0;   s1_offset <= '0;
        end else begin
            s1_valid <= in_valid; s1_ch <= in_ch; s1_sample <= in_sample;
            s1_scale <= in_scale; s1_offset <= in_offset;
        end
    end

    // Stage 2: full-width signed product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0; s2_ch <= '0; s2_prod <= '0; s2_offset <= '0;
        end else begin
            s2_valid  <= s1_valid;
            s2_ch     <= s1_ch;
            s2_prod   <= PROD_W'(s1_sample) * PROD_W'(s1_scale);
            s2_offset <= s1_offset;
        end
    end

    // Offset add and clamp to the output range.
    always_comb begin
        sum_w  = SUM_W'(s2_prod) + SUM_W'(s2_offset);
        sum_hi = sum_w[SUM_W-1:COEF_W-1];
        if (sum_hi == '0 || sum_hi == '1)
            clamped = sum_w[COEF_W-1:0];
        else if (sum_w[SUM_W-1])
            clamped = {1'b1, {(COEF_W-1){1'b0}}};
        else
            clamped = {1'b0, {(COEF_W-1){1'b1}}};
    end

    // Stage 3: register the clamped result with its tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_ch <= '0; out_data <= '0;
        end else begin
            out_valid <= s2_valid;
            out_ch    <= s2_ch;
            out_data  <= clamped;
        end
    end

    // R7: two non-negative terms never wrap to a negative result.
    a_r7_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_prod[PROD_W-1] && !s2_offset[COEF_W-1]) |=> !out_data[COEF_W-1]);
    // R7: two negative terms never wrap to a non-negative result.
    a_r7_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_prod[PROD_W-1] && s2_offset[COEF_W-1]) |=> out_data[COEF_W-1]);

endmodule

// File: rtl/adc_cal_corrector.sv
// Top of the calibration corrector: slot decode, coefficient bank and
// multiply-add pipeline. Assumes one sample per cycle at most and that
// in_ch is below NUM_CH.
module adc_cal_corrector
    import adc_cal_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int COEF_W   = 24,
    parameter int NUM_CH   = 2,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SLOT_W  = $clog2(NUM_SLOTS),
    localparam int ADDR_W  = $clog2(NUM_SLOTS * 2 * NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic signed [COEF_W-1:0]   cfg_wdata,
    input  logic [FREQ_CODE_W-1:0]     freq_code,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_ch,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_ch,
    output logic signed [COEF_W-1:0]   out_data
);

    logic [SLOT_W-1:0]        sel_slot;
    logic signed [COEF_W-1:0] cur_scale, cur_offset;

    cal_slot_decode #(.SLOT_W(SLOT_W)) u_decode (
        .freq_code (freq_code),
        .slot      (sel_slot)
    );

    cal_coef_bank #(
        .COEF_W (COEF_W), .NUM_CH (NUM_CH), .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W), .CH_W   (CH_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .smp_valid (in_valid),
        .rd_slot   (sel_slot),
        .rd_ch     (in_ch),
        .rd_scale  (cur_scale),
        .rd_offset (cur_offset)
    );

    cal_mac_pipe #(
        .SAMPLE_W (SAMPLE_W), .COEF_W (COEF_W), .CH_W (CH_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ch     (in_ch),
        .in_sample (in_sample),
        .in_scale  (cur_scale),
        .in_offset (cur_offset),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_data  (out_data)
    );

    // R4: the decoded slot always names an existing slot.
    a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_slot) < NUM_SLOTS);
    // R5: every accepted sample emerges three edges later.
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);
    // R5: the tag travels with the sample.
    a_r5_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 (out_ch == $past(in_ch, 3)));
    // R5: no output without an input three edges earlier.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

endmodule

// File: tb/adc_cal_corrector_test.sv
// Scoreboard bench: the driver computes expected results from a model
// of the requirements and queues them; a monitor compares on arrival.
module adc_cal_corrector_test;

    localparam int NW = 28;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [4:0]         cfg_addr = '0;
    logic signed [23:0] cfg_wdata = '0;
    logic [7:0]         freq_code = '0;
    logic               in_valid = 1'b0;
    logic [0:0]         in_ch = '0;
    logic signed [13:0] in_sample = '0;
    logic               out_valid;
    logic [0:0]         out_ch;
    logic signed [23:0] out_data;

    adc_cal_corrector uut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .freq_code (freq_code), .in_valid (in_valid),
        .in_ch (in_ch), .in_sample (in_sample), .out_valid (out_valid),
        .out_ch (out_ch), .out_data (out_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic signed [23:0] d;
        logic               ch;
        int                 due;
        string              req;
    } exp_t;

    exp_t               sb[$];
    int                 cyc = 0;
    int                 n_chk = 0;
    int                 n_bad = 0;
    bit                 done = 0;
    logic signed [23:0] m_shadow [NW];
    logic signed [23:0] m_active [NW];
    logic [31:0]        lfsr = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int slot_of(input int code);
        case (code)
            50: return 1;   80: return 2;   100: return 3;
            110: return 4;  120: return 5;  125: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic signed [23:0] model(input int n, input int code, input int ch);
        longint s, o, r;
        s = longint'(m_active[slot_of(code) * 4 + ch * 2]);
        o = longint'(m_active[slot_of(code) * 4 + ch * 2 + 1]);
        r = longint'(n) * s + o;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return 24'(r);
    endfunction

    // One cycle of stimulus, entered and left at a falling edge.
    task automatic step(input bit v, input int ch, input int n, input int code,
                        input bit we, input int addr, input int data, input string req);
        exp_t e;
        in_valid = v; in_ch = 1'(ch); in_sample = 14'(n); freq_code = 8'(code);
        cfg_we = we; cfg_addr = 5'(addr); cfg_wdata = 24'(data);
        if (v) begin
            e.d = model(n, code, ch); e.ch = 1'(ch); e.due = cyc + 3; e.req = req;
            sb.push_back(e);
        end
        if (!v) for (int w = 0; w < NW; w++) m_active[w] = m_shadow[w];
        if (we && addr < NW) m_shadow[addr] = 24'(data);
        @(negedge clk);
    endtask

    task automatic smp(input int ch, input int n, input int code, input string req);
        step(1'b1, ch, n, code, 1'b0, 0, 0, req);
    endtask

    task automatic wr(input int addr, input int data, input string req);
        step(1'b0, 0, 0, 0, 1'b1, addr, data, req);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 0, 0, 0, 1'b0, 0, 0, "");
    endtask

    // Monitor: compare arrivals with the queue head, value, tag and cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5: unexpected output data=%0d, expected none", out_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (out_data !== e.d || out_ch !== e.ch || cyc != e.due) begin
                        n_bad++;
                        $display("FAIL %s: data=%0d ch=%0d cyc=%0d, expected data=%0d ch=%0d cyc=%0d",
                                 e.req, out_data, out_ch, cyc, e.d, e.ch, e.due);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                n_chk++; n_bad++;
                $display("FAIL R5: no output at cyc=%0d, expected data=%0d", cyc, sb[0].d);
                void'(sb.pop_front());
            end
        end
    end

    function automatic int rnd(input int m);
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        return int'(lfsr % 32'(m));
    endfunction

    initial begin
        int codes [11] = '{0, 50, 80, 100, 110, 120, 125, 7, 255, 49, 126};
        for (int w = 0; w < NW; w++) begin m_shadow[w] = '0; m_active[w] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 24'sd0) begin
            n_bad++;
            $display("FAIL R1: out_valid=%0b out_data=%0d, expected 0 0", out_valid, out_data);
        end
        smp(0, 5000, 0, "R1"); smp(1, -3000, 80, "R1");
        idle(2);
        // R3, R6: slot 0, both channels, extreme and mid codes
        wr(0, 540, "R2"); wr(1, 1000, "R2"); wr(2, 560, "R2"); wr(3, -2000, "R2");
        idle(2);
        smp(0, 8191, 0, "R3"); smp(1, -8192, 0, "R3"); smp(0, 0, 0, "R6");
        smp(1, 1234, 0, "R6"); smp(0, -1, 0, "R3"); smp(1, 0, 0, "R6");
        // R4: distinct coefficients per slot, sweep known and unknown codes
        for (int s = 1; s < 7; s++)
            for (int c = 0; c < 2; c++) begin
                wr(s * 4 + c * 2, 100 * (s + 1) + 7 * c, "R2");
                wr(s * 4 + c * 2 + 1, 11 * s - 3 * c, "R2");
            end
        idle(2);
        foreach (codes[i]) begin
            smp(0, 4000 - i * 700, codes[i], "R4");
            smp(1, -4000 + i * 650, codes[i], "R4");
        end
        idle(1);
        // R7: clamp both ways and a just-in-range value
        wr(24, 8388607, "R7"); wr(25, 8388607, "R7"); wr(26, -8388608, "R7"); wr(27, 0, "R7");
        idle(1);
        smp(0, 8191, 125, "R7"); smp(0, -8192, 125, "R7"); smp(1, -8192, 125, "R7");
        smp(1, 8191, 125, "R7");
        wr(24, 1024, "R7"); wr(25, 0, "R7"); idle(1);
        smp(0, 8191, 125, "R7"); smp(0, -8192, 125, "R7");
        // R8: writes during an unbroken burst stay hidden until a gap
        for (int i = 0; i < 10; i++)
            step(1'b1, i % 2, 300 * i - 1500, 0, (i == 2 || i == 5), (i == 2) ? 0 : 3,
                 (i == 2) ? 2222 : 777, "R8");
        idle(1);
        for (int i = 0; i < 4; i++) smp(i % 2, 1000 + i, 0, "R8");
        // R2: addresses past the table are ignored
        wr(28, 99999, "R2"); wr(29, -5, "R2"); wr(30, 12345, "R2"); wr(31, 1, "R2");
        idle(2);
        foreach (codes[i]) begin smp(0, 2500, codes[i], "R2"); smp(1, -2500, codes[i], "R2"); end
        // R3..R8 mixed: pseudo-random stream with scattered writes
        for (int i = 0; i < 400; i++)
            step(rnd(4) != 0, rnd(2), rnd(16384) - 8192, codes[rnd(11)], rnd(8) == 0,
                 rnd(32), rnd(1 << 20) - (1 << 19), "R8");
        idle(6);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R5: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1; n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule